// File: doc/BRIEF.md
# Vector Element Loop Sequencer

This block expands one scalar-form instruction into a run of per-element micro-operations. An instruction arrives over a valid/ready handshake together with a vector length, a scalar-or-vector flag for each of its three operands (two sources, one destination), the three base register numbers and an optional predicate mask. While the loop runs, the block keeps the program counter still and steps an element index upward. For every active element it offers one micro-operation carrying the element index and the three register numbers. A vector operand's register number is its base plus the index. A scalar operand's register number is its base on every step. When the loop is over it raises a one-cycle program-counter advance strobe and becomes free for the next instruction.

The block has no separate opcodes for broadcast, select and plain vector operations. They follow from the operand flags and the mask. Scalar sources with a vector destination broadcast one value into every active destination element. A vector source with a scalar destination and a single-bit mask copies the chosen element into the scalar. In that case the loop stops as soon as that element has been issued. Any length from zero up to the maximum is legal, including lengths that are not powers of two. An instruction that is not flagged as vectorised behaves as a single element.

Top module: `vloop_seq`

## Requirements
- R1: After reset, and after a reset applied in the middle of a loop, instr_ready is 1 and elem_valid and pc_advance are 0.
- R2: For each accepted instruction, pc_advance is high for exactly one cycle, after the last element handshake. It is never high in the same cycle as elem_valid. instr_ready is low from the cycle after acceptance until the cycle after pc_advance.
- R3: Elements are issued in strictly ascending index order over 0..VL-1 for any VL from 1 to VL_MAX, whether or not VL is a power of two. A VL above VL_MAX is treated as VL_MAX.
- R4: On each issued element, a vector-flagged operand's register number is (base + elem_idx) mod 2^REG_W. A scalar-flagged operand's register number is its base.
- R5: With pred_en = 1 on a vectorised instruction, element i is issued only if pred_mask bit i (bit 0 = element 0) is 1, and inactive elements are skipped. With pred_en = 0 every element below VL is active. Mask bits at or above VL have no effect.
- R6: A vectorised instruction with VL = 0 issues no element, and pc_advance is high in the cycle right after acceptance.
- R7: If the destination is scalar and at least one source is vector, the loop ends after the first issued element. With a single-bit mask this selects exactly that element.
- R8: While elem_valid is 1 and elem_ready is 0, elem_valid stays 1, and elem_idx and the three register numbers stay unchanged on the next cycle.
- R9: An instruction with instr_vec = 0 issues exactly one element, index 0, with all three register numbers equal to their bases. VL, the operand flags and the mask are ignored.
- R10: Scalar sources with a vector destination (no mask or a multi-bit mask) give one element per active index, with source registers fixed at their bases and destination register base + index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction offered |
| instr_ready | output | 1 | Sequencer idle and able to accept |
| instr_vec | input | 1 | Instruction is vectorised |
| instr_vl | input | VLW | Vector length |
| src1_is_vec | input | 1 | Source 1 is a vector operand |
| src2_is_vec | input | 1 | Source 2 is a vector operand |
| dst_is_vec | input | 1 | Destination is a vector operand |
| src1_base | input | REG_W | Source 1 base register |
| src2_base | input | REG_W | Source 2 base register |
| dst_base | input | REG_W | Destination base register |
| pred_en | input | 1 | Apply the predicate mask |
| pred_mask | input | VL_MAX | Per-element enable, bit i for element i |
| elem_valid | output | 1 | Element micro-operation offered |
| elem_ready | input | 1 | Element micro-operation taken |
| elem_idx | output | IDXW | Element index |
| elem_src1 | output | REG_W | Source 1 register for this element |
| elem_src2 | output | REG_W | Source 2 register for this element |
| elem_dst | output | REG_W | Destination register for this element |
| pc_advance | output | 1 | One-cycle strobe: loop done, program counter moves on |

## Verification
The hardest situation to reach is an element that stalls with ready low while later elements in the mask are inactive and the loop may stop early. That mix decides both what the outputs must hold and when the advance strobe may rise. The stimulus table pairs sparse masks and select-form operand flags with a ready pattern that drops every third cycle. Each held offer is compared against the previous cycle, and every handshake is compared against the expected index set. A reset applied halfway through a long loop shows that the block comes back idle without a stray strobe.

// File: rtl/vloop_pkg.sv
package vloop_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;

  typedef struct packed {
    logic src1_vec;
    logic src2_vec;
    logic dst_vec;
  } op_mode_t;

  // Scalar destination fed by a vector source: only one element may land.
  function automatic logic stops_on_first(op_mode_t m);
    return !m.dst_vec && (m.src1_vec || m.src2_vec);
  endfunction

endpackage

// File: rtl/vloop_ctrl.sv
module vloop_ctrl
  import vloop_pkg::*;
#(
  parameter int VLW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [VLW-1:0] start_vl,
  input  logic           elem_active,
  input  logic           elem_ready,
  input  logic           stop_on_fire,
  output logic           run,
  output logic [VLW-1:0] idx,
  output logic           at_end,
  output logic           issue
);

  seq_state_e     state_q, state_d;
  logic [VLW-1:0] idx_q, idx_d;
  logic [VLW-1:0] vl_q, vl_d;
  logic           idx_en, vl_en;

  assign run    = (state_q == ST_RUN);
  assign idx    = idx_q;
  assign at_end = run && (idx_q >= vl_q);
  assign issue  = run && !at_end && elem_active;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    vl_d    = vl_q;
    idx_en  = 1'b0;
    vl_en   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_RUN;
          idx_d   = '0;
          idx_en  = 1'b1;
          vl_d    = start_vl;
          vl_en   = 1'b1;
        end
      end
      ST_RUN: begin
        if (at_end) begin
          state_d = ST_IDLE;
        end else if (!elem_active) begin
          idx_d  = idx_q + 1'b1;
          idx_en = 1'b1;
        end else if (elem_ready) begin
          idx_d  = stop_on_fire ? vl_q : idx_q + 1'b1;
          idx_en = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      vl_q    <= '0;
    end else begin
      state_q <= state_d;
      if (idx_en) idx_q <= idx_d;
      if (vl_en)  vl_q  <= vl_d;
    end
  end

endmodule

// File: rtl/vloop_pred.sv
module vloop_pred #(
  parameter int VL_MAX = 16,
  parameter int VLW    = 5
) (
  input  logic [VL_MAX-1:0] mask,
  input  logic [VLW-1:0]    idx,
  output logic              active
);

  logic [VL_MAX-1:0] shifted;

  always_comb begin
    shifted = mask >> idx;
    active  = (idx < VLW'(VL_MAX)) && shifted[0];
  end

endmodule

// File: rtl/vloop_regmap.sv
module vloop_regmap #(
  parameter int REG_W = 7,
  parameter int VLW   = 5
) (
  input  logic [REG_W-1:0] base,
  input  logic             is_vec,
  input  logic [VLW-1:0]   idx,
  output logic [REG_W-1:0] reg_num
);

  logic [REG_W-1:0] offset;

  always_comb begin
    offset  = is_vec ? REG_W'(idx) : '0;
    reg_num = base + offset;
  end

endmodule

// File: rtl/vloop_seq.sv
module vloop_seq
  import vloop_pkg::*;
#(
  parameter int VL_MAX = 16,
  parameter int REG_W  = 7,
  localparam int VLW   = $clog2(VL_MAX + 1),
  localparam int IDXW  = (VL_MAX > 1) ? $clog2(VL_MAX) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  output logic              instr_ready,
  input  logic              instr_vec,
  input  logic [VLW-1:0]    instr_vl,
  input  logic              src1_is_vec,
  input  logic              src2_is_vec,
  input  logic              dst_is_vec,
  input  logic [REG_W-1:0]  src1_base,
  input  logic [REG_W-1:0]  src2_base,
  input  logic [REG_W-1:0]  dst_base,
  input  logic              pred_en,
  input  logic [VL_MAX-1:0] pred_mask,
  output logic              elem_valid,
  input  logic              elem_ready,
  output logic [IDXW-1:0]   elem_idx,
  output logic [REG_W-1:0]  elem_src1,
  output logic [REG_W-1:0]  elem_src2,
  output logic [REG_W-1:0]  elem_dst,
  output logic              pc_advance
);

  localparam int NUM_OPS = 3;

  logic              accept;
  logic              run;
  logic              at_end;
  logic              issue;
  logic              active;
  logic [VLW-1:0]    idx;

  op_mode_t          mode_d, mode_q;
  logic [VLW-1:0]    vl_eff;
  logic [VL_MAX-1:0] mask_d, mask_q;
  logic [REG_W-1:0]  base_d [NUM_OPS];
  logic [REG_W-1:0]  base_q [NUM_OPS];
  logic [NUM_OPS-1:0] vec_flag;
  logic [REG_W-1:0]  reg_out [NUM_OPS];

  assign instr_ready = !run;
  assign accept      = instr_valid && instr_ready;

  // Normalise the incoming instruction: a plain instruction is a
  // one-element all-scalar loop with every element enabled.
  always_comb begin
    if (instr_vec) begin
      mode_d.src1_vec = src1_is_vec;
      mode_d.src2_vec = src2_is_vec;
      mode_d.dst_vec  = dst_is_vec;
      vl_eff          = (instr_vl > VLW'(VL_MAX)) ? VLW'(VL_MAX) : instr_vl;
      mask_d          = pred_en ? pred_mask : '1;
    end else begin
      mode_d = '0;
      vl_eff = VLW'(1);
      mask_d = '1;
    end
    base_d[0] = src1_base;
    base_d[1] = src2_base;
    base_d[2] = dst_base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      mask_q <= '0;
      for (int k = 0; k < NUM_OPS; k++) base_q[k] <= '0;
    end else if (accept) begin
      mode_q <= mode_d;
      mask_q <= mask_d;
      for (int k = 0; k < NUM_OPS; k++) base_q[k] <= base_d[k];
    end
  end

  assign vec_flag = {mode_q.dst_vec, mode_q.src2_vec, mode_q.src1_vec};

  vloop_ctrl #(.VLW(VLW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (accept),
    .start_vl    (vl_eff),
    .elem_active (active),
    .elem_ready  (elem_ready),
    .stop_on_fire(stops_on_first(mode_q)),
    .run         (run),
    .idx         (idx),
    .at_end      (at_end),
    .issue       (issue)
  );

  vloop_pred #(.VL_MAX(VL_MAX), .VLW(VLW)) u_pred (
    .mask  (mask_q),
    .idx   (idx),
    .active(active)
  );

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    vloop_regmap #(.REG_W(REG_W), .VLW(VLW)) u_map (
      .base   (base_q[g]),
      .is_vec (vec_flag[g]),
      .idx    (idx),
      .reg_num(reg_out[g])
    );
  end

  assign elem_valid = issue;
  assign elem_idx   = idx[IDXW-1:0];
  assign elem_src1  = reg_out[0];
  assign elem_src2  = reg_out[1];
  assign elem_dst   = reg_out[2];
  assign pc_advance = at_end;

endmodule

// File: rtl/vloop_seq_chk.sv
module vloop_seq_chk #(
  parameter int VL_MAX = 16,
  parameter int REG_W  = 7,
  parameter int VLW    = 5,
  parameter int IDXW   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              instr_valid,
  input logic              instr_ready,
  input logic              instr_vec,
  input logic [VLW-1:0]    instr_vl,
  input logic              elem_valid,
  input logic              elem_ready,
  input logic [IDXW-1:0]   elem_idx,
  input logic [REG_W-1:0]  elem_src1,
  input logic [REG_W-1:0]  elem_src2,
  input logic [REG_W-1:0]  elem_dst,
  input logic              pc_advance
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    instr_ready |-> (!elem_valid && !pc_advance)); // R1

  AST_PC_NOT_WITH_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    elem_valid |-> !pc_advance); // R2

  AST_PC_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    pc_advance |=> (!pc_advance && instr_ready)); // R2

  AST_IDX_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_valid && elem_ready) |=> (!elem_valid || (elem_idx > $past(elem_idx)))); // R3

  AST_ZERO_VL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && instr_ready && instr_vec && (instr_vl == '0)) |=> (pc_advance && !elem_valid)); // R6

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_valid && !elem_ready) |=> (elem_valid && $stable(elem_idx) && $stable(elem_src1)
                                     && $stable(elem_src2) && $stable(elem_dst))); // R8

  AST_PLAIN_ONE_ELEM: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && instr_ready && !instr_vec) |=> (elem_valid && (elem_idx == '0))); // R9

endmodule

bind vloop_seq vloop_seq_chk #(
  .VL_MAX(VL_MAX),
  .REG_W (REG_W),
  .VLW   (VLW),
  .IDXW  (IDXW)
) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .instr_valid(instr_valid),
  .instr_ready(instr_ready),
  .instr_vec  (instr_vec),
  .instr_vl   (instr_vl),
  .elem_valid (elem_valid),
  .elem_ready (elem_ready),
  .elem_idx   (elem_idx),
  .elem_src1  (elem_src1),
  .elem_src2  (elem_src2),
  .elem_dst   (elem_dst),
  .pc_advance (pc_advance)
);

// File: tb/test_vloop_seq.sv
`timescale 1ns/1ps
module test_vloop_seq;

  localparam int VL_MAX = 16;
  localparam int REG_W  = 7;
  localparam int VLW    = 5;
  localparam int IDXW   = 4;
  localparam int NVEC   = 12;

  typedef struct packed {
    logic        vec;
    logic [4:0]  vl;
    logic        s1v;
    logic        s2v;
    logic        dv;
    logic        pen;
    logic [15:0] mask;
    logic [6:0]  b1;
    logic [6:0]  b2;
    logic [6:0]  bd;
    logic        stall;
    logic [15:0] expm;
  } stim_t;

  // vec, vl, s1v, s2v, dv, pen, mask, b1, b2, bd, stall, expected issued set
  localparam stim_t TABLE [NVEC] = '{
    '{1'b1, 5'd5,  1'b1, 1'b1, 1'b1, 1'b0, 16'h0000, 7'd10, 7'd20,  7'd30,  1'b0, 16'h001F}, // R3 odd length
    '{1'b1, 5'd7,  1'b1, 1'b1, 1'b1, 1'b1, 16'hFF59, 7'd1,  7'd40,  7'd80,  1'b1, 16'h0059}, // R5 sparse mask
    '{1'b1, 5'd3,  1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 7'd5,  7'd6,   7'd50,  1'b0, 16'h0007}, // R10 broadcast
    '{1'b1, 5'd4,  1'b0, 1'b0, 1'b1, 1'b1, 16'h0005, 7'd7,  7'd8,   7'd60,  1'b1, 16'h0005}, // R10 masked broadcast
    '{1'b1, 5'd8,  1'b1, 1'b0, 1'b0, 1'b1, 16'h0010, 7'd20, 7'd3,   7'd9,   1'b1, 16'h0010}, // R7 select
    '{1'b1, 5'd6,  1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 7'd33, 7'd4,   7'd11,  1'b0, 16'h0001}, // R7 early stop
    '{1'b0, 5'd9,  1'b1, 1'b1, 1'b1, 1'b1, 16'h0000, 7'd12, 7'd13,  7'd14,  1'b0, 16'h0001}, // R9 plain
    '{1'b1, 5'd16, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0000, 7'd64, 7'd2,   7'd96,  1'b1, 16'hFFFF}, // R8 full + stall
    '{1'b1, 5'd0,  1'b1, 1'b1, 1'b1, 1'b0, 16'h0000, 7'd1,  7'd2,   7'd3,   1'b0, 16'h0000}, // R6 zero length
    '{1'b1, 5'd4,  1'b1, 1'b1, 1'b1, 1'b1, 16'h0000, 7'd1,  7'd2,   7'd3,   1'b0, 16'h0000}, // R5 all masked off
    '{1'b1, 5'd5,  1'b1, 1'b1, 1'b1, 1'b0, 16'h0000, 7'd126,7'd0,   7'd125, 1'b1, 16'h001F}, // R4 wrap
    '{1'b1, 5'd20, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0000, 7'd0,  7'd16,  7'd32,  1'b0, 16'hFFFF}  // R3 clamp
  };

  string TAGS [NVEC] = '{"R3", "R5", "R10", "R10", "R7", "R7", "R9", "R8", "R6", "R5", "R4", "R3"};

  logic              clk = 1'b0;
  logic              rst_n;
  logic              instr_valid;
  logic              instr_ready;
  logic              instr_vec;
  logic [VLW-1:0]    instr_vl;
  logic              src1_is_vec, src2_is_vec, dst_is_vec;
  logic [REG_W-1:0]  src1_base, src2_base, dst_base;
  logic              pred_en;
  logic [VL_MAX-1:0] pred_mask;
  logic              elem_valid;
  logic              elem_ready;
  logic [IDXW-1:0]   elem_idx;
  logic [REG_W-1:0]  elem_src1, elem_src2, elem_dst;
  logic              pc_advance;

  int n_chk  = 0;
  int n_fail = 0;

  vloop_seq #(.VL_MAX(VL_MAX), .REG_W(REG_W)) i_vloop_seq (
    .clk(clk), .rst_n(rst_n),
    .instr_valid(instr_valid), .instr_ready(instr_ready),
    .instr_vec(instr_vec), .instr_vl(instr_vl),
    .src1_is_vec(src1_is_vec), .src2_is_vec(src2_is_vec), .dst_is_vec(dst_is_vec),
    .src1_base(src1_base), .src2_base(src2_base), .dst_base(dst_base),
    .pred_en(pred_en), .pred_mask(pred_mask),
    .elem_valid(elem_valid), .elem_ready(elem_ready), .elem_idx(elem_idx),
    .elem_src1(elem_src1), .elem_src2(elem_src2), .elem_dst(elem_dst),
    .pc_advance(pc_advance)
  );

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_reg(input bit vecmode, input bit opv, input int base, input int idx);
    return (vecmode && opv) ? ((base + idx) % (1 << REG_W)) : base;
  endfunction

  task automatic run_entry(input stim_t s, input string tag);
    bit          finished = 0;
    bit          prev_wait = 0;
    int          last = -1;
    int          cyc = 0;
    int          pidx = 0;
    int          p1 = 0, p2 = 0, pd = 0;
    logic [15:0] got = '0;
    @(negedge clk);
    check(instr_ready == 1'b1, "R2", "instr_ready when idle", instr_ready, 1);
    instr_vec   = s.vec;   instr_vl    = s.vl;
    src1_is_vec = s.s1v;   src2_is_vec = s.s2v;  dst_is_vec = s.dv;
    pred_en     = s.pen;   pred_mask   = s.mask;
    src1_base   = s.b1;    src2_base   = s.b2;   dst_base   = s.bd;
    instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
    while (!finished && cyc < 200) begin
      elem_ready = s.stall ? ((cyc % 3) != 2) : 1'b1;
      if (prev_wait) begin
        check(elem_valid && int'(elem_idx) == pidx && int'(elem_src1) == p1
              && int'(elem_src2) == p2 && int'(elem_dst) == pd,
              "R8", "offer held during stall", elem_idx, pidx);
      end
      if (elem_valid) begin
        if (elem_ready) begin
          int i = int'(elem_idx);
          check(i > last, "R3", "ascending index", i, last + 1);
          check(s.expm[i] == 1'b1, tag, "issued index allowed", i, -1);
          check(int'(elem_src1) == exp_reg(s.vec, s.s1v, int'(s.b1), i), "R4", "src1 register",
                elem_src1, exp_reg(s.vec, s.s1v, int'(s.b1), i));
          check(int'(elem_src2) == exp_reg(s.vec, s.s2v, int'(s.b2), i), "R4", "src2 register",
                elem_src2, exp_reg(s.vec, s.s2v, int'(s.b2), i));
          check(int'(elem_dst) == exp_reg(s.vec, s.dv, int'(s.bd), i), "R4", "dst register",
                elem_dst, exp_reg(s.vec, s.dv, int'(s.bd), i));
          got[i] = 1'b1;
          last   = i;
        end
        prev_wait = !elem_ready;
        pidx = int'(elem_idx); p1 = int'(elem_src1); p2 = int'(elem_src2); pd = int'(elem_dst);
      end else begin
        prev_wait = 0;
      end
      if (pc_advance) begin
        check(!elem_valid, "R2", "no offer with pc_advance", elem_valid, 0);
        finished = 1;
      end
      cyc++;
      @(negedge clk);
    end
    check(finished, "R2", "pc_advance reached", finished, 1);
    check(got == s.expm, tag, "issued element set", got, s.expm);
    elem_ready = 1'b1;
  endtask

  initial begin : watchdog
    #(4 * 150000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    rst_n = 1'b0;
    instr_valid = 1'b0; instr_vec = 1'b0; instr_vl = '0;
    src1_is_vec = 1'b0; src2_is_vec = 1'b0; dst_is_vec = 1'b0;
    src1_base = '0; src2_base = '0; dst_base = '0;
    pred_en = 1'b0; pred_mask = '0; elem_ready = 1'b1;
    repeat (3) @(negedge clk);
    check(instr_ready && !elem_valid && !pc_advance, "R1", "state in reset",
          {instr_ready, elem_valid, pc_advance}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    check(instr_ready && !elem_valid && !pc_advance, "R1", "idle after reset",
          {instr_ready, elem_valid, pc_advance}, 3'b100);

    for (int n = 0; n < NVEC; n++) run_entry(TABLE[n], TAGS[n]);

    // R6: zero length finishes in the very next cycle
    @(negedge clk);
    instr_vec = 1'b1; instr_vl = '0; pred_en = 1'b0; instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
    check(pc_advance && !elem_valid, "R6", "strobe right after accept",
          {pc_advance, elem_valid}, 2'b10);
    @(negedge clk);
    check(instr_ready == 1'b1, "R2", "ready after strobe", instr_ready, 1);

    // R1: reset in the middle of a long stalled loop
    instr_vec = 1'b1; instr_vl = 5'd12; src1_is_vec = 1'b1; src2_is_vec = 1'b1;
    dst_is_vec = 1'b1; pred_en = 1'b0; instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
    elem_ready  = 1'b1;
    repeat (2) @(negedge clk);
    elem_ready = 1'b0;
    check(elem_valid && !instr_ready, "R2", "busy mid loop", {elem_valid, instr_ready}, 2'b10);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    elem_ready = 1'b1;
    @(negedge clk);
    check(instr_ready && !elem_valid && !pc_advance, "R1", "idle after mid-loop reset",
          {instr_ready, elem_valid, pc_advance}, 3'b100);
    @(negedge clk);
    check(!pc_advance && !elem_valid, "R1", "no stray activity", {pc_advance, elem_valid}, 0);

    // block still works after the reset
    run_entry(TABLE[0], "R3");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule